// File: doc/BRIEF.md
# HMAC Key Register File

This block holds the secret key for a hash engine that computes keyed-hash message authentication codes. Software loads key words through a register port that writes or reads one 64-bit word per request, addressed by a 4-bit index. A 3-bit mode input names the active hash algorithm. The algorithm sets two things: the byte order used on the host side, and how many key words join the padded key.

The hash core reads the key through a second, read-only port. It names a word index and asks for either the inner-pad or the outer-pad form. The block returns the stored word XORed with the pad pattern one cycle later, so software never has to build the padded key itself. Words are always stored in big-endian order. In the little-endian mode the host port reverses the bytes of each word in both directions, which keeps the pad path free of any byte reordering.

Top module: `hmac_key_bank`

## Requirements
- R1: A synchronous active-low reset clears all sixteen key words to zero. After reset a host read returns 0, and a pad request returns only the pad pattern.
- R2: A host read request (host_req=1, host_we=0) raises host_rvalid and presents the addressed word on host_rdata on the following clock edge. In any SHA mode, a word written and then read back comes out unchanged.
- R3: Mode code 0 is MD5. In this mode the bytes of each word are reversed on a host write and again on a host read: host bits 7:0 are stored in bits 63:56, and so on. A word written and read in MD5 mode comes back unchanged. The same word read in a SHA mode comes back byte-reversed.
- R4: With pad_sel=0 the pad port returns the stored word XOR 0x3636363636363636 (inner pad). With pad_sel=1 it returns the stored word XOR 0x5C5C5C5C5C5C5C5C (outer pad). The pad path applies no byte reversal in any mode.
- R5: pad_valid and pad_word update on the clock edge after a pad request. pad_valid is low in every cycle that does not follow a pad request.
- R6: Mode codes 0 (MD5), 1 (SHA-1), 2 (SHA-224), 3 (SHA-256), and the unused codes 6 and 7, use 8 active words. A pad request for index 8 to 15 in these modes treats the key word as zero and returns the bare pad pattern. Host writes to those indices are still stored and still readable.
- R7: Mode codes 4 (SHA-384) and 5 (SHA-512) use all 16 words. A pad request for index 8 to 15 in these modes returns the stored word with the pad applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode | input | 3 | Hash algorithm code (0 MD5 … 5 SHA-512) |
| host_req | input | 1 | Host access request |
| host_we | input | 1 | 1 = write, 0 = read |
| host_idx | input | 4 | Key word index |
| host_wdata | input | 64 | Write data |
| host_rvalid | output | 1 | Read data valid, one cycle after a read request |
| host_rdata | output | 64 | Read data |
| pad_req | input | 1 | Pad word request from the hash core |
| pad_sel | input | 1 | 0 = inner pad, 1 = outer pad |
| pad_idx | input | 4 | Key word index for the pad port |
| pad_valid | output | 1 | Pad word valid |
| pad_word | output | 64 | Padded key word |

## Verification
The bench uses the default parameters: 64-bit words, 16 words in the bank, 8 active words in narrow modes, and pad bytes 0x36 and 0x5C. With these values the upper eight indices cross the boundary between narrow and wide modes. One word can therefore be stored under a narrow mode, shown to be masked on the pad port, and then shown in padded form once the mode switches to a wide one. The full 8-byte word width also places a byte-reversal error at every byte lane, so a written and swapped word exposes an error in any lane against the hand-computed expected values.

// File: rtl/hkey_pkg.sv
// Package: mode decoding shared by the key bank and its checker.
// Assumes a 3-bit mode code; codes 6 and 7 behave as narrow big-endian modes.
package hkey_pkg;
    localparam int unsigned MODE_W = 3;

    localparam logic [MODE_W-1:0] MODE_MD5    = 3'd0;
    localparam logic [MODE_W-1:0] MODE_SHA1   = 3'd1;
    localparam logic [MODE_W-1:0] MODE_SHA224 = 3'd2;
    localparam logic [MODE_W-1:0] MODE_SHA256 = 3'd3;
    localparam logic [MODE_W-1:0] MODE_SHA384 = 3'd4;
    localparam logic [MODE_W-1:0] MODE_SHA512 = 3'd5;

    // True for the algorithms built on 64-bit words (full key bank active).
    function automatic logic mode_is_wide(input logic [MODE_W-1:0] m);
        return (m == MODE_SHA384) || (m == MODE_SHA512);
    endfunction

    // True for the one algorithm whose host-side key data is little-endian.
    function automatic logic mode_is_le(input logic [MODE_W-1:0] m);
        return m == MODE_MD5;
    endfunction
endpackage

// File: rtl/hkey_swap.sv
// Byte-order reverser: when en is set, byte k of din moves to byte NB-1-k.
// Assumes WORD_W is a multiple of 8. Purely combinational.
module hkey_swap #(
    parameter int unsigned WORD_W = 64
) (
    input  logic              en,
    input  logic [WORD_W-1:0] din,
    output logic [WORD_W-1:0] dout
);
    localparam int unsigned NB = WORD_W / 8;

    logic [WORD_W-1:0] rev;

    // One lane per byte: mirror position inside the word.
    for (genvar b = 0; b < NB; b++) begin : g_lane
        assign rev[8*b +: 8] = din[8*(NB-1-b) +: 8];
    end

    // Select reversed or straight word.
    always_comb dout = en ? rev : din;
endmodule

// File: rtl/hkey_store.sv
// Key word storage: NUM_WORDS registers of WORD_W bits, one write per cycle.
// Assumes the write data has already been brought into canonical big-endian order.
module hkey_store #(
    parameter int unsigned WORD_W    = 64,
    parameter int unsigned NUM_WORDS = 16,
    parameter int unsigned IDX_W     = $clog2(NUM_WORDS)
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [IDX_W-1:0]                  wr_idx,
    input  logic [WORD_W-1:0]                 wr_data,
    output logic [NUM_WORDS-1:0][WORD_W-1:0]  words
);
    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        // Hold word w; clear on reset, load when addressed by a write.
        always_ff @(posedge clk) begin
            if (!rst_n)
                words[w] <= '0;
            else if (wr_en && (wr_idx == IDX_W'(w)))
                words[w] <= wr_data;
        end
    end
endmodule

// File: rtl/hkey_pad.sv
// Pad generator: picks one stored word, masks it to zero past the active
// word count, XORs the selected pad pattern in, and registers the result.
// Assumes words are held in canonical order (no byte reversal needed here).
module hkey_pad #(
    parameter int unsigned WORD_W       = 64,
    parameter int unsigned NUM_WORDS    = 16,
    parameter int unsigned NARROW_WORDS = 8,
    parameter logic [7:0]  IPAD_BYTE    = 8'h36,
    parameter logic [7:0]  OPAD_BYTE    = 8'h5C,
    parameter int unsigned IDX_W        = $clog2(NUM_WORDS)
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              req,
    input  logic                              sel,
    input  logic [IDX_W-1:0]                  idx,
    input  logic                              wide,
    input  logic [NUM_WORDS-1:0][WORD_W-1:0]  words,
    output logic                              valid,
    output logic [WORD_W-1:0]                 word
);
    localparam int unsigned   NB       = WORD_W / 8;
    localparam logic [IDX_W:0] CNT_WIDE = (IDX_W+1)'(NUM_WORDS);
    localparam logic [IDX_W:0] CNT_NARR = (IDX_W+1)'(NARROW_WORDS);
    localparam logic [WORD_W-1:0] IPAT  = {NB{IPAD_BYTE}};
    localparam logic [WORD_W-1:0] OPAT  = {NB{OPAD_BYTE}};

    logic [IDX_W:0]    active;
    logic [WORD_W-1:0] key_w;
    logic [WORD_W-1:0] padded;

    // Active word count and masked key word for the requested index.
    always_comb begin
        active = wide ? CNT_WIDE : CNT_NARR;
        key_w  = ({1'b0, idx} < active) ? words[idx] : '0;
        padded = key_w ^ (sel ? OPAT : IPAT);
    end

    // Register the padded word and its valid flag, one cycle after request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
            word  <= '0;
        end else begin
            valid <= req;
            if (req)
                word <= padded;
        end
    end
endmodule

// File: rtl/hmac_key_bank.sv
// Top: keyed-hash key register file with a host port and a pad port.
// Host data is byte-reversed on entry and exit when the mode is little-endian;
// the pad port reads canonical words. One host operation per cycle.
module hmac_key_bank #(
    parameter int unsigned WORD_W       = 64,
    parameter int unsigned NUM_WORDS    = 16,
    parameter int unsigned NARROW_WORDS = 8,
    parameter logic [7:0]  IPAD_BYTE    = 8'h36,
    parameter logic [7:0]  OPAD_BYTE    = 8'h5C,
    parameter int unsigned IDX_W        = $clog2(NUM_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        mode,
    input  logic              host_req,
    input  logic              host_we,
    input  logic [IDX_W-1:0]  host_idx,
    input  logic [WORD_W-1:0] host_wdata,
    output logic              host_rvalid,
    output logic [WORD_W-1:0] host_rdata,
    input  logic              pad_req,
    input  logic              pad_sel,
    input  logic [IDX_W-1:0]  pad_idx,
    output logic              pad_valid,
    output logic [WORD_W-1:0] pad_word
);
    import hkey_pkg::*;

    logic                             le_mode;
    logic                             wide_mode;
    logic                             wr_en;
    logic [WORD_W-1:0]                wr_canon;
    logic [WORD_W-1:0]                rd_host;
    logic [NUM_WORDS-1:0][WORD_W-1:0] words;

    // Decode the mode into byte order and width class.
    always_comb begin
        le_mode   = mode_is_le(mode);
        wide_mode = mode_is_wide(mode);
        wr_en     = host_req && host_we;
    end

    hkey_swap #(.WORD_W(WORD_W)) u_swap_wr (
        .en   (le_mode),
        .din  (host_wdata),
        .dout (wr_canon)
    );

    hkey_store #(
        .WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS), .IDX_W(IDX_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (host_idx),
        .wr_data (wr_canon),
        .words   (words)
    );

    hkey_swap #(.WORD_W(WORD_W)) u_swap_rd (
        .en   (le_mode),
        .din  (words[host_idx]),
        .dout (rd_host)
    );

    // Register host read data; hold the last value when no read is made.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_rvalid <= 1'b0;
            host_rdata  <= '0;
        end else begin
            host_rvalid <= host_req && !host_we;
            if (host_req && !host_we)
                host_rdata <= rd_host;
        end
    end

    hkey_pad #(
        .WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS), .NARROW_WORDS(NARROW_WORDS),
        .IPAD_BYTE(IPAD_BYTE), .OPAD_BYTE(OPAD_BYTE), .IDX_W(IDX_W)
    ) u_pad (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (pad_req),
        .sel   (pad_sel),
        .idx   (pad_idx),
        .wide  (wide_mode),
        .words (words),
        .valid (pad_valid),
        .word  (pad_word)
    );
endmodule

// File: rtl/hmac_key_bank_chk.sv
// Checker for hmac_key_bank: port-level timing and pad-value properties.
// Assumes it is bound to the top with matching port names.
module hmac_key_bank_chk #(
    parameter int unsigned WORD_W       = 64,
    parameter int unsigned NUM_WORDS    = 16,
    parameter int unsigned NARROW_WORDS = 8,
    parameter logic [7:0]  IPAD_BYTE    = 8'h36,
    parameter logic [7:0]  OPAD_BYTE    = 8'h5C,
    parameter int unsigned IDX_W        = $clog2(NUM_WORDS)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        mode,
    input logic              host_req,
    input logic              host_we,
    input logic [IDX_W-1:0]  host_idx,
    input logic [WORD_W-1:0] host_wdata,
    input logic              host_rvalid,
    input logic [WORD_W-1:0] host_rdata,
    input logic              pad_req,
    input logic              pad_sel,
    input logic [IDX_W-1:0]  pad_idx,
    input logic              pad_valid,
    input logic [WORD_W-1:0] pad_word
);
    import hkey_pkg::*;

    localparam int unsigned       NB   = WORD_W / 8;
    localparam logic [WORD_W-1:0] IPAT = {NB{IPAD_BYTE}};
    localparam logic [WORD_W-1:0] OPAT = {NB{OPAD_BYTE}};
    localparam logic [IDX_W:0]    NARR = (IDX_W+1)'(NARROW_WORDS);

    logic [1:0] age;

    // Count edges since reset, saturating, so deep $past only looks after reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            age <= '0;
        else if (age != 2'd3)
            age <= age + 2'd1;
    end

    AST_PAD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        pad_req |=> pad_valid);                                          // R5
    AST_PAD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !pad_req |=> !pad_valid);                                        // R5
    AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (host_req && !host_we) |=> host_rvalid);                         // R2
    AST_NARROW_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_req && !mode_is_wide(mode) && ({1'b0, pad_idx} >= NARR))
        |=> (pad_word == ($past(pad_sel) ? OPAT : IPAT)));               // R6
    AST_WIDE_PAD: assert property (@(posedge clk) disable iff (!rst_n)
        ((age == 2'd3) && pad_valid
         && $past(host_req && host_we, 2)
         && ($past(mode, 2) == MODE_SHA512) && ($past(mode) == MODE_SHA512)
         && ($past(pad_idx) == $past(host_idx, 2)))
        |-> (pad_word == ($past(host_wdata, 2) ^ ($past(pad_sel) ? OPAT : IPAT)))); // R4
endmodule

bind hmac_key_bank hmac_key_bank_chk #(
    .WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS), .NARROW_WORDS(NARROW_WORDS),
    .IPAD_BYTE(IPAD_BYTE), .OPAD_BYTE(OPAD_BYTE), .IDX_W(IDX_W)
) u_chk (.*);

// File: tb/sim_hmac_key_bank.sv
// Bench for hmac_key_bank: vector table walked by one loop, then directed cases.
module sim_hmac_key_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  mode = 3'd0;
    logic        host_req = 1'b0;
    logic        host_we = 1'b0;
    logic [3:0]  host_idx = '0;
    logic [63:0] host_wdata = '0;
    logic        host_rvalid;
    logic [63:0] host_rdata;
    logic        pad_req = 1'b0;
    logic        pad_sel = 1'b0;
    logic [3:0]  pad_idx = '0;
    logic        pad_valid;
    logic [63:0] pad_word;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;   // 200 MHz

    hmac_key_bank u0 (.*);

    // Vector: mode, index, write data, pad select, expected pad word, expected readback
    typedef struct packed {
        logic [2:0]  m;
        logic [3:0]  idx;
        logic [63:0] wd;
        logic        sel;
        logic [63:0] exp_pad;
        logic [63:0] exp_rd;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{3'd5, 4'd3,  64'h0123456789ABCDEF, 1'b0, 64'h37157351BF9DFBD9, 64'h0123456789ABCDEF},
        '{3'd4, 4'd12, 64'hFFFF0000AAAA5555, 1'b1, 64'hA3A35C5CF6F60909, 64'hFFFF0000AAAA5555},
        '{3'd0, 4'd2,  64'h0011223344556677, 1'b0, 64'h4150637205142736, 64'h0011223344556677},
        '{3'd1, 4'd7,  64'h8000000000000001, 1'b1, 64'hDC5C5C5C5C5C5C5D, 64'h8000000000000001},
        '{3'd3, 4'd10, 64'h1122334455667788, 1'b0, 64'h3636363636363636, 64'h1122334455667788},
        '{3'd2, 4'd0,  64'hDEADBEEFCAFEF00D, 1'b1, 64'h82F1E2B396A2AC51, 64'hDEADBEEFCAFEF00D}
    };

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic host_write(input logic [2:0] m, input logic [3:0] i, input logic [63:0] d);
        @(negedge clk);
        mode = m; host_req = 1'b1; host_we = 1'b1; host_idx = i; host_wdata = d;
        @(negedge clk);
        host_req = 1'b0; host_we = 1'b0;
    endtask

    task automatic host_read(input logic [2:0] m, input logic [3:0] i,
                             output logic [63:0] d, output logic v);
        @(negedge clk);
        mode = m; host_req = 1'b1; host_we = 1'b0; host_idx = i;
        @(negedge clk);
        host_req = 1'b0;
        d = host_rdata; v = host_rvalid;
    endtask

    task automatic pad_read(input logic [2:0] m, input logic [3:0] i, input logic s,
                            output logic [63:0] d, output logic v);
        @(negedge clk);
        mode = m; pad_req = 1'b1; pad_idx = i; pad_sel = s;
        @(negedge clk);
        pad_req = 1'b0;
        d = pad_word; v = pad_valid;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [63:0] d;
        logic        v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state on both ports
        host_read(3'd5, 4'd5, d, v);
        check("R1 host read after reset", d, 64'h0);
        pad_read(3'd5, 4'd5, 1'b1, d, v);
        check("R1 pad after reset", d, 64'h5C5C5C5C5C5C5C5C);
        @(negedge clk);
        check("R5 pad_valid low when idle", {63'b0, pad_valid}, 64'h0);

        // Table walk: R2/R3 readback, R4/R6 pad values
        for (int k = 0; k < NV; k++) begin
            host_write(VECS[k].m, VECS[k].idx, VECS[k].wd);
            host_read(VECS[k].m, VECS[k].idx, d, v);
            check($sformatf("R2 rvalid vec%0d", k), {63'b0, v}, 64'h1);
            check($sformatf("R2/R3 readback vec%0d", k), d, VECS[k].exp_rd);
            pad_read(VECS[k].m, VECS[k].idx, VECS[k].sel, d, v);
            check($sformatf("R5 pad_valid vec%0d", k), {63'b0, v}, 64'h1);
            check($sformatf("R4/R6 pad word vec%0d", k), d, VECS[k].exp_pad);
        end

        // R3: word written in MD5 mode reads back reversed in a SHA mode
        host_read(3'd5, 4'd2, d, v);
        check("R3 cross-mode readback", d, 64'h7766554433221100);

        // R7: index 10 written under a narrow mode becomes active in a wide mode
        pad_read(3'd5, 4'd10, 1'b0, d, v);
        check("R7 wide upper word ipad", d, 64'h27140572635041BE);

        // R6: unused code 7 acts as narrow: index 12 masked, but still host-readable
        pad_read(3'd7, 4'd12, 1'b1, d, v);
        check("R6 code7 masks upper index", d, 64'h5C5C5C5C5C5C5C5C);
        host_read(3'd7, 4'd12, d, v);
        check("R6 upper word still stored", d, 64'hFFFF0000AAAA5555);

        // R5: valid drops the cycle after a single request
        @(negedge clk);
        check("R5 pad_valid single pulse", {63'b0, pad_valid}, 64'h0);

        // R2: host_rvalid low when no read was made
        check("R2 rvalid idle", {63'b0, host_rvalid}, 64'h0);

        // R1: reset again clears stored words
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        host_read(3'd5, 4'd3, d, v);
        check("R1 cleared after second reset", d, 64'h0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule